// File: doc/BRIEF.md
# Transmit Bit Retiming Handshake Unit

This unit sits between a host controller and the transmit data input of an FSK modulator. It lets the host hand over one data bit per modulator bit period through a ready/strobe handshake, so that every bit reaches the modulator exactly on the internal bit boundary. At each bit boundary, marked by a one-cycle bit-rate tick, the unit pulls its active-low ready output low. The host then sets up the next bit, raises the strobe and lowers it again. The unit captures the bit on the strobe's rising edge and drives it to the modulator from the next tick for one whole bit period.

The host selects the mode only through the static level of the strobe. While the strobe stays high, retiming is off and the host's data goes straight to the modulator as asynchronous data. When the host holds the strobe low at a bit boundary, retiming starts. When the strobe stays high across two bit boundaries after a capture, retiming ends. A rate select input marks the low transmit rate. At that rate retiming is never offered and data always passes straight through.

The strobe and the data are brought into the system clock domain by a synchroniser chain of parameterised depth. If the host misses a boundary, the previous bit is sent again and a sticky underrun flag is raised.

Top module: `tx_retime_unit`

## Requirements
- R1: While not retiming (the strobe has been high, or the low rate is selected), modBit equals dataIn combinationally and readyN is 1. Bit ticks do not change readyN.
- R2: In pass-through mode with the rate select low, a bit tick seen while the synchronised strobe is low enters retiming. On the next cycle readyN is 0 and modBit holds the synchronised dataIn level. Later changes of dataIn do not reach modBit.
- R3: In retiming, the first rising edge of the synchronised strobe captures the synchronised dataIn into a holding register. readyN stays 0 while the strobe is high.
- R4: The cycle after the synchronised strobe falling edge is seen, readyN returns to 1, and modBit still shows the previous bit.
- R5: At the next bit tick after a complete strobe pulse, modBit takes the captured bit and readyN goes to 0 on the following cycle.
- R6: If a bit tick arrives while readyN is 0 and no strobe rising edge has been seen, modBit repeats the previous bit and underrunFlag becomes 1. The flag stays 1 until reset.
- R7: If the strobe is raised after ready goes low and then stays high, the first tick applies the captured bit and the second tick returns the unit to pass-through (R1 behaviour).
- R8: While lowRate is 1, the unit is in pass-through regardless of the strobe, even if it was retiming. readyN is 1 and ticks do not start retiming.
- R9: After reset, readyN is 1, underrunFlag is 0 and the unit is in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle pulse at each internal bit boundary |
| strobeIn | input | 1 | Host strobe; static high selects pass-through |
| dataIn | input | 1 | Host transmit data bit |
| lowRate | input | 1 | 1 selects the low transmit rate (no retiming) |
| readyN | output | 1 | Active-low request for the next bit |
| modBit | output | 1 | Bit driven to the modulator |
| underrunFlag | output | 1 | Sticky flag: a bit boundary passed without a new bit |

## Verification
The hardest state to reach from the ports is the exit window. The strobe has been raised for a capture but never lowered, so the unit sits between the first and second ticks of the exit rule. Only the second tick may release it to pass-through. The stimulus gets there by holding the data at the last retimed level, raising the strobe after ready goes low, and then issuing two ticks with no falling edge between them. Pass-through is checked only after the second tick. The underrun case is reached by issuing a tick while ready is still low, and its flag is then carried through the low-rate and exit scenarios to show that it is sticky.

// File: rtl/txrt_pkg.sv
package txrt_pkg;

  typedef enum logic [2:0] {
    sBypass   = 3'd0,
    sWaitRise = 3'd1,
    sWaitFall = 3'd2,
    sLoaded   = 3'd3,
    sExitPend = 3'd4
  } rtState_e;

  typedef struct packed {
    logic seedHeld;
    logic loadCapture;
    logic applyCapture;
    logic readyLow;
    logic readyHigh;
    logic flagUnderrun;
  } rtStrobes_t;

endpackage

// File: rtl/txrt_ctrl.sv
module txrt_ctrl
  import txrt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       strobeIn,
  input  logic       dataIn,
  input  logic       lowRate,
  output rtStrobes_t ctl,
  output logic       bypassMode,
  output logic       dataSync
);

  localparam int LastStage = SYNC_STAGES - 1;

  logic [LastStage:0] strobePipe;
  logic [LastStage:0] dataPipe;
  logic               strobeLast;
  logic               strobeSync;
  logic               strobeRise;
  logic               strobeFall;
  rtState_e           state, nextState;

  genvar g;
  generate
    for (g = 0; g <= LastStage; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          strobePipe[g] <= 1'b1;
          dataPipe[g]   <= 1'b0;
        end else if (g == 0) begin
          strobePipe[g] <= strobeIn;
          dataPipe[g]   <= dataIn;
        end else begin
          strobePipe[g] <= strobePipe[(g > 0) ? g - 1 : 0];
          dataPipe[g]   <= dataPipe[(g > 0) ? g - 1 : 0];
        end
      end
    end
  endgenerate

  assign strobeSync = strobePipe[LastStage];
  assign dataSync   = dataPipe[LastStage];
  assign strobeRise = strobeSync & ~strobeLast;
  assign strobeFall = ~strobeSync & strobeLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeLast <= 1'b1;
      state      <= sBypass;
    end else begin
      strobeLast <= strobeSync;
      state      <= nextState;
    end
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (lowRate) begin
      nextState = sBypass;
      if (state != sBypass) ctl.readyHigh = 1'b1;
    end else begin
      case (state)
        sBypass: begin
          if (bitTick && !strobeSync) begin
            ctl.seedHeld = 1'b1;
            ctl.readyLow = 1'b1;
            nextState    = sWaitRise;
          end
        end
        sWaitRise: begin
          if (bitTick) ctl.flagUnderrun = 1'b1;
          if (strobeRise) begin
            ctl.loadCapture = 1'b1;
            nextState       = sWaitFall;
          end
        end
        sWaitFall: begin
          if (bitTick && strobeFall) begin
            ctl.applyCapture = 1'b1;
            ctl.readyLow     = 1'b1;
            nextState        = sWaitRise;
          end else if (bitTick) begin
            ctl.applyCapture = 1'b1;
            nextState        = sExitPend;
          end else if (strobeFall) begin
            ctl.readyHigh = 1'b1;
            nextState     = sLoaded;
          end
        end
        sLoaded: begin
          if (bitTick) begin
            ctl.applyCapture = 1'b1;
            ctl.readyLow     = 1'b1;
            nextState        = sWaitRise;
          end
        end
        sExitPend: begin
          if (bitTick) begin
            ctl.readyHigh = 1'b1;
            nextState     = sBypass;
          end else if (strobeFall) begin
            nextState = sWaitRise;
          end
        end
        default: begin
          ctl.readyHigh = 1'b1;
          nextState     = sBypass;
        end
      endcase
    end
  end

  assign bypassMode = (state == sBypass);

  assert_lowrate_forces_bypass_R8: assert property (
    @(posedge clk) disable iff (!rstN)
    lowRate |=> (state == sBypass));

  assert_rise_captures_R3: assert property (
    @(posedge clk) disable iff (!rstN)
    (state == sWaitRise && strobeRise && !lowRate) |=> (state == sWaitFall));

  assert_exit_needs_second_tick_R7: assert property (
    @(posedge clk) disable iff (!rstN)
    (state == sWaitFall && bitTick && !strobeFall && !lowRate) |=> (state == sExitPend));

endmodule

// File: rtl/txrt_datapath.sv
module txrt_datapath
  import txrt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rtStrobes_t ctl,
  input  logic       dataSync,
  input  logic       bypassMode,
  output logic       readyN,
  output logic       heldBit,
  output logic       underrunFlag
);

  logic captureBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyN       <= 1'b1;
      heldBit      <= 1'b0;
      captureBit   <= 1'b0;
      underrunFlag <= 1'b0;
    end else begin
      if (ctl.seedHeld)          heldBit <= dataSync;
      else if (ctl.applyCapture) heldBit <= captureBit;
      if (ctl.loadCapture) captureBit <= dataSync;
      if (ctl.readyLow)       readyN <= 1'b0;
      else if (ctl.readyHigh) readyN <= 1'b1;
      if (ctl.flagUnderrun) underrunFlag <= 1'b1;
    end
  end

  assert_underrun_sticky_R6: assert property (
    @(posedge clk) disable iff (!rstN)
    underrunFlag |=> underrunFlag);

  assert_repeat_on_underrun_R6: assert property (
    @(posedge clk) disable iff (!rstN)
    ctl.flagUnderrun |=> $stable(heldBit));

  assert_bypass_ready_high_R1: assert property (
    @(posedge clk) disable iff (!rstN)
    bypassMode |-> readyN);

  assert_apply_takes_capture_R5: assert property (
    @(posedge clk) disable iff (!rstN)
    (ctl.applyCapture && !ctl.loadCapture) |=> (heldBit == $past(captureBit)));

endmodule

// File: rtl/tx_retime_unit.sv
module tx_retime_unit
  import txrt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic strobeIn,
  input  logic dataIn,
  input  logic lowRate,
  output logic readyN,
  output logic modBit,
  output logic underrunFlag
);

  rtStrobes_t ctl;
  logic       bypassMode;
  logic       dataSync;
  logic       heldBit;

  txrt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .strobeIn   (strobeIn),
    .dataIn     (dataIn),
    .lowRate    (lowRate),
    .ctl        (ctl),
    .bypassMode (bypassMode),
    .dataSync   (dataSync)
  );

  txrt_datapath uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .dataSync     (dataSync),
    .bypassMode   (bypassMode),
    .readyN       (readyN),
    .heldBit      (heldBit),
    .underrunFlag (underrunFlag)
  );

  assign modBit = (bypassMode | lowRate) ? dataIn : heldBit;

endmodule

// File: tb/sim_tx_retime_unit.sv
module sim_tx_retime_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic strobeIn = 1'b1;
  logic dataIn = 1'b0;
  logic lowRate = 1'b0;
  logic readyN, modBit, underrunFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_retime_unit #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .strobeIn(strobeIn),
    .dataIn(dataIn), .lowRate(lowRate), .readyN(readyN), .modBit(modBit),
    .underrunFlag(underrunFlag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTick();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  task automatic testReset();
    doReset();
    check("R9 readyN after reset", readyN, 1'b1);
    check("R9 underrun after reset", underrunFlag, 1'b0);
    dataIn = 1'b1; #1;
    check("R9 pass-through after reset", modBit, 1'b1);
    dataIn = 1'b0;
  endtask

  task automatic testBypass();
    strobeIn = 1'b1;
    waitCyc(4);
    for (int i = 0; i < 4; i++) begin
      dataIn = i[0]; #1;
      check("R1 modBit follows dataIn", modBit, i[0]);
      pulseTick();
      check("R1 readyN stays high on tick", readyN, 1'b1);
    end
  endtask

  task automatic enterRetime(input logic lvl);
    dataIn = lvl;
    strobeIn = 1'b0;
    waitCyc(4);
    pulseTick();
  endtask

  task automatic sendBit(input logic b, input logic prev);
    dataIn = b;
    waitCyc(2);
    strobeIn = 1'b1;
    waitCyc(4);
    check("R3 readyN low while strobe high", readyN, 1'b0);
    strobeIn = 1'b0;
    waitCyc(4);
    check("R4 readyN high after strobe fall", readyN, 1'b1);
    check("R4 modBit still previous bit", modBit, prev);
    pulseTick();
    check("R5 captured bit applied at tick", modBit, b);
    check("R5 readyN low after tick", readyN, 1'b0);
  endtask

  task automatic testRetime();
    enterRetime(1'b1);
    check("R2 readyN low on entry", readyN, 1'b0);
    check("R2 modBit seeded", modBit, 1'b1);
    dataIn = 1'b0; #1;
    check("R2 dataIn isolated in retiming", modBit, 1'b1);
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b0);
    sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b1);
  endtask

  task automatic testUnderrun();
    dataIn = 1'b1;
    check("R6 no underrun yet", underrunFlag, 1'b0);
    pulseTick();
    check("R6 bit repeated on underrun", modBit, 1'b0);
    check("R6 underrun flag set", underrunFlag, 1'b1);
    sendBit(1'b1, 1'b0);
    check("R6 underrun flag sticky", underrunFlag, 1'b1);
  endtask

  task automatic testExit();
    dataIn = 1'b0;
    waitCyc(2);
    strobeIn = 1'b1;
    waitCyc(4);
    pulseTick();
    check("R7 last bit applied on first tick", modBit, 1'b0);
    pulseTick();
    check("R7 readyN high after exit", readyN, 1'b1);
    dataIn = 1'b1; #1;
    check("R7 pass-through after exit", modBit, 1'b1);
    dataIn = 1'b0; #1;
    check("R7 pass-through follows low", modBit, 1'b0);
  endtask

  task automatic testLowRate();
    enterRetime(1'b1);
    check("R8 precondition retiming", readyN, 1'b0);
    lowRate = 1'b1;
    waitCyc(2);
    check("R8 readyN high at low rate", readyN, 1'b1);
    dataIn = 1'b0; #1;
    check("R8 modBit follows dataIn at low rate", modBit, 1'b0);
    pulseTick();
    pulseTick();
    check("R8 ticks do not start retiming", readyN, 1'b1);
    dataIn = 1'b1; #1;
    check("R8 still pass-through", modBit, 1'b1);
    check("R6 flag survives low rate", underrunFlag, 1'b1);
    lowRate = 1'b0;
    strobeIn = 1'b1;
    waitCyc(4);
  endtask

  initial begin
    waitCyc(2);
    testReset();
    testBypass();
    testRetime();
    testUnderrun();
    testExit();
    testLowRate();
    testReset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule